// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block is a purely combinational unsigned adder. It adds two 32-bit operands and a carry input, and it produces a 32-bit sum and a carry output. The operands are cut into 4-bit groups. Each group adds its own slice locally. Each group also reports whether it would pass an incoming carry straight through (group propagate) and whether it produces a carry by itself (group generate).

A lookahead unit takes four such group pairs and the carry entering its 16-bit section. From these it forms the carry into every group and the carry leaving the section, all in parallel. The two 16-bit sections are joined end to end: the carry leaving the lower section is the carry entering the upper one.

The block has no state, so it can sit in any single-cycle datapath. Its widths are parameters: the data width, the group width and the number of groups per section.

Top module: `cla_adder_top`

## Requirements
- R1: For every input, {carry_out, sum} equals the 33-bit unsigned value op_a + op_b + carry_in.
- R2: A 4-bit group whose operand slices add to exactly 15 passes its incoming carry to the next group unchanged. With op_a = 0x0000000F and op_b = 0x00000000, carry_in = 1 gives sum 0x00000010 and carry_in = 0 gives sum 0x0000000F.
- R3: A 4-bit group whose operand slices add to 16 or more delivers a carry into the next group whatever carry it receives. With op_a = op_b = 0x00000008, sum is 0x00000010 for both values of carry_in, apart from bit 0, which follows carry_in.
- R4: Inside a section, the carry into each group equals the generate of the group below, or that group's propagate ANDed with the carry into that group.
- R5: The carry out of bit 15 (the lower section) enters bit 16 (the upper section). 0x0000FFFF + 0x00000001 gives sum 0x00010000 and carry_out 0.
- R6: When every bit propagates (op_b = ~op_a), carry_in reaches carry_out across all 32 bits. With carry_in = 1 the sum is 0 and carry_out is 1; with carry_in = 0 the sum is 0xFFFFFFFF and carry_out is 0.
- R7: 0xFFFFFFFF + 0xFFFFFFFF + 1 gives sum 0xFFFFFFFF and carry_out 1, the largest result the block can produce.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First addend |
| op_b | input | 32 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 32 | Low 32 bits of the result |
| carry_out | output | 1 | Carry out of bit 31 |

## Verification
Assertions are evaluated on every change of the inputs, and they check four relations:
- inside each group, the local ripple carry agrees with the group's propagate and generate;
- the expanded lookahead carries match the one-step carry recurrence;
- the first group of each section sees that section's carry input;
- the whole result equals the arithmetic sum.

Whether a particular carry path is actually exercised can only be shown by the bench's scenarios. These cover nibble patterns repeated in every group, full-width propagation, the boundary between the sections and random operands.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Default geometry of the adder
  parameter int unsigned DEF_DATA_W   = 32;
  parameter int unsigned DEF_GRP_W    = 4;
  parameter int unsigned DEF_GRPS_SEC = 4;

  // Carry signals that a group reports to its lookahead unit
  typedef struct packed {
    logic prop;
    logic gen;
  } grp_pg_t;
endpackage

// File: rtl/cla_group_add.sv
module cla_group_add
  import cla_pkg::*;
#(
  parameter int unsigned GRP_W = DEF_GRP_W
) (
  input  logic [GRP_W-1:0] a,
  input  logic [GRP_W-1:0] b,
  input  logic             c_in,
  output logic [GRP_W-1:0] s,
  output grp_pg_t          pg
);
  logic [GRP_W-1:0] bit_p;
  logic [GRP_W-1:0] bit_g;
  logic [GRP_W:0]   rip_c;
  logic             grp_gen;
  logic             term;

  assign bit_p = a ^ b;
  assign bit_g = a & b;

  // Local ripple from the group carry-in
  assign rip_c[0] = c_in;
  for (genvar i = 0; i < GRP_W; i++) begin : g_rip
    assign rip_c[i+1] = bit_g[i] | (bit_p[i] & rip_c[i]);
    assign s[i]       = bit_p[i] ^ rip_c[i];
  end

  // Group generate, expanded without the carry-in
  always_comb begin
    grp_gen = 1'b0;
    for (int j = 0; j < GRP_W; j++) begin
      term = bit_g[j];
      for (int m = j + 1; m < GRP_W; m++) term = term & bit_p[m];
      grp_gen = grp_gen | term;
    end
  end

  assign pg.prop = &bit_p;
  assign pg.gen  = grp_gen;

  // R4 support: the local ripple must agree with the lookahead view of the group
  always_comb begin
    if (!$isunknown({a, b, c_in})) begin
      assert_group_carry_R4: assert (rip_c[GRP_W] == (pg.gen | (pg.prop & c_in)))
        else $error("group ripple carry disagrees with group P/G");
      assert_pg_exclusive_R3: assert (!(pg.prop && pg.gen))
        else $error("group both propagates and generates");
    end
  end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead
  import cla_pkg::*;
#(
  parameter int unsigned NUM_GRP = DEF_GRPS_SEC
) (
  input  grp_pg_t [NUM_GRP-1:0] pg,
  input  logic                  c_in,
  output logic    [NUM_GRP-1:0] grp_c,
  output logic                  c_out
);
  logic [NUM_GRP:0] carry;
  logic             acc;
  logic             term;

  // Every carry is formed directly from cin and the (P,G) pairs below it
  always_comb begin
    carry[0] = c_in;
    for (int k = 1; k <= NUM_GRP; k++) begin
      term = c_in;
      for (int m = 0; m < k; m++) term = term & pg[m].prop;
      acc = term;
      for (int j = 0; j < k; j++) begin
        term = pg[j].gen;
        for (int m = j + 1; m < k; m++) term = term & pg[m].prop;
        acc = acc | term;
      end
      carry[k] = acc;
    end
  end

  assign grp_c = carry[NUM_GRP-1:0];
  assign c_out = carry[NUM_GRP];

  // R4: the expanded carries obey the one-step recurrence
  always_comb begin
    if (!$isunknown({pg, c_in})) begin
      for (int k = 0; k < NUM_GRP - 1; k++) begin
        assert_grp_carry_R4: assert (grp_c[k+1] == (pg[k].gen | (pg[k].prop & grp_c[k])))
          else $error("lookahead carry %0d breaks recurrence", k + 1);
      end
      assert_sec_cout_R4: assert (c_out == (pg[NUM_GRP-1].gen | (pg[NUM_GRP-1].prop & grp_c[NUM_GRP-1])))
        else $error("lookahead carry-out breaks recurrence");
    end
  end
endmodule

// File: rtl/cla_section.sv
module cla_section
  import cla_pkg::*;
#(
  parameter int unsigned GRP_W   = DEF_GRP_W,
  parameter int unsigned NUM_GRP = DEF_GRPS_SEC
) (
  input  logic [GRP_W*NUM_GRP-1:0] a,
  input  logic [GRP_W*NUM_GRP-1:0] b,
  input  logic                     c_in,
  output logic [GRP_W*NUM_GRP-1:0] s,
  output logic                     c_out
);
  localparam int unsigned SEC_W = GRP_W * NUM_GRP;

  grp_pg_t [NUM_GRP-1:0] pg;
  logic    [NUM_GRP-1:0] grp_c;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    cla_group_add #(.GRP_W(GRP_W)) u_grp (
      .a    (a[g*GRP_W +: GRP_W]),
      .b    (b[g*GRP_W +: GRP_W]),
      .c_in (grp_c[g]),
      .s    (s[g*GRP_W +: GRP_W]),
      .pg   (pg[g])
    );
  end

  cla_lookahead #(.NUM_GRP(NUM_GRP)) u_cla (
    .pg    (pg),
    .c_in  (c_in),
    .grp_c (grp_c),
    .c_out (c_out)
  );

  // R5 support: the section carry-in reaches its lowest group
  always_comb begin
    if (!$isunknown(c_in)) begin
      assert_sec_cin_R5: assert (grp_c[0] == c_in)
        else $error("section carry-in not delivered to group 0");
    end
  end

  // R1 at section level
  always_comb begin
    if (!$isunknown({a, b, c_in})) begin
      assert_sec_sum_R1: assert ({c_out, s} == ({1'b0, a} + {1'b0, b} + {{SEC_W{1'b0}}, c_in}))
        else $error("section result wrong");
    end
  end
endmodule

// File: rtl/cla_adder_top.sv
module cla_adder_top
  import cla_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned GRP_W    = DEF_GRP_W,
  parameter int unsigned GRPS_SEC = DEF_GRPS_SEC
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              carry_in,
  output logic [DATA_W-1:0] sum,
  output logic              carry_out
);
  localparam int unsigned SEC_W   = GRP_W * GRPS_SEC;
  localparam int unsigned NUM_SEC = DATA_W / SEC_W;

  logic [NUM_SEC:0] sec_c;

  // Sections chained end to end (R5)
  assign sec_c[0] = carry_in;
  for (genvar k = 0; k < NUM_SEC; k++) begin : g_sec
    cla_section #(.GRP_W(GRP_W), .NUM_GRP(GRPS_SEC)) u_sec (
      .a     (op_a[k*SEC_W +: SEC_W]),
      .b     (op_b[k*SEC_W +: SEC_W]),
      .c_in  (sec_c[k]),
      .s     (sum[k*SEC_W +: SEC_W]),
      .c_out (sec_c[k+1])
    );
  end
  assign carry_out = sec_c[NUM_SEC];

  always_comb begin
    if (!$isunknown({op_a, op_b, carry_in})) begin
      assert_total_sum_R1: assert ({carry_out, sum} ==
                                   ({1'b0, op_a} + {1'b0, op_b} + {{DATA_W{1'b0}}, carry_in}))
        else $error("adder result wrong");
      assert_no_undef_cout_R6: assert (!$isunknown(carry_out))
        else $error("carry chain broken");
    end
  end
endmodule

// File: tb/test_cla_adder_top.sv
module test_cla_adder_top;
  logic        clk;
  logic [31:0] op_a, op_b;
  logic        carry_in;
  logic [31:0] sum;
  logic        carry_out;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  cla_adder_top i_cla_adder_top (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum(sum), .carry_out(carry_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Apply one vector, settle, and compare against an independent sum
  task automatic apply_chk(input logic [31:0] a, input logic [31:0] b,
                           input logic c, input string tag);
    logic [32:0] exp;
    op_a = a; op_b = b; carry_in = c;
    @(negedge clk);
    exp = {1'b0, a} + {1'b0, b} + {32'b0, c};
    checks++;
    if ({carry_out, sum} !== exp) begin
      errors++;
      $display("FAIL %s: a=%h b=%h cin=%b got %h expected %h", tag, a, b, c,
               {carry_out, sum}, exp);
    end
  endtask

  task automatic test_zero_state();
    apply_chk(32'h0, 32'h0, 1'b0, "R1 zero");
  endtask

  task automatic test_nibble_patterns();
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        for (int c = 0; c < 2; c++)
          apply_chk({8{x[3:0]}}, {8{y[3:0]}}, c[0], "R1 R4 nibble");
  endtask

  task automatic test_propagate_group();
    apply_chk(32'h0000000F, 32'h0, 1'b1, "R2 prop cin1");
    apply_chk(32'h0000000F, 32'h0, 1'b0, "R2 prop cin0");
    apply_chk(32'h00000F0F, 32'h000000F0, 1'b1, "R2 prop two groups");
  endtask

  task automatic test_generate_group();
    apply_chk(32'h00000008, 32'h00000008, 1'b0, "R3 gen cin0");
    apply_chk(32'h00000008, 32'h00000008, 1'b1, "R3 gen cin1");
    apply_chk(32'h000000F8, 32'h00000008, 1'b0, "R3 gen then prop");
  endtask

  task automatic test_section_join();
    apply_chk(32'h0000FFFF, 32'h00000001, 1'b0, "R5 join");
    apply_chk(32'h0000FFFF, 32'h00000000, 1'b1, "R5 join cin");
    apply_chk(32'h00008000, 32'h00008000, 1'b0, "R5 gen at 15");
    apply_chk(32'h7FFF0000, 32'h0000FFFF, 1'b1, "R5 long prop");
  endtask

  task automatic test_full_propagate();
    apply_chk(32'hFFFFFFFF, 32'h0, 1'b1, "R6 ripple all cin1");
    apply_chk(32'hFFFFFFFF, 32'h0, 1'b0, "R6 ripple all cin0");
    apply_chk(32'hA5A5A5A5, 32'h5A5A5A5A, 1'b1, "R6 mixed prop");
    apply_chk(32'h12345678, ~32'h12345678, 1'b0, "R6 complement");
  endtask

  task automatic test_max();
    apply_chk(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, "R7 max");
    apply_chk(32'h80000000, 32'h80000000, 1'b0, "R7 top bit");
  endtask

  task automatic test_random();
    for (int n = 0; n < 2000; n++)
      apply_chk($urandom, $urandom, 1'($urandom), "R1 random");
  endtask

  initial begin
    op_a = '0; op_b = '0; carry_in = 1'b0;
    @(negedge clk);
    test_zero_state();
    test_nibble_patterns();
    test_propagate_group();
    test_generate_group();
    test_section_join();
    test_full_propagate();
    test_max();
    test_random();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule